// File: doc/BRIEF.md
# Two-Wire EEPROM Request Sequencer

This block turns host requests ("write these N bytes starting at address A" or "read N bytes starting at address A") into the byte-level command stream of a two-wire serial EEPROM. It sits above a command engine that handles the bit timing on the bus. That engine accepts four commands: START (a repeated START when the bus is already active), WRITE a byte (which reports whether the device acknowledged it), READ a byte (with the host's ACK or NACK) and STOP. The sequencer sends one command at a time and waits for the engine's response before it sends the next.

Writes go out in segments. No segment crosses a page boundary, because the device wraps addresses inside a page. After each segment the sequencer polls the device with its write address until the device acknowledges it. Polling replaces a fixed programming delay, and it gives up after a set number of refused attempts.

A read first performs a dummy write of the word address. It then sends a repeated START and the read address, and streams the bytes out. Write data comes in and read data goes out on valid/ready byte streams. A one-cycle done pulse, carrying an error code, ends every request.

Top module: `eeprom_seq`

## Requirements
- R1: A write request sends START, the device address with R/W=0, the high address byte (address bits above 7, zero-extended), the low address byte, the data bytes and then STOP. The bytes land at consecutive addresses. Command codes are 0=START, 1=WRITE, 2=READ, 3=STOP.
- R2: A write segment holds at most PAGE_BYTES data bytes and stays inside one page. A request that runs past the end of a page is split, and each segment has its own START, address and STOP.
- R3: Right after the STOP of each segment, the block polls by sending START and the device address with R/W=0. A NACK leads to STOP and a new poll. An ACK leads to STOP, after which the next segment starts or the request completes.
- R4: After MAX_POLL refused polls in one polling phase, the request ends with error code 2 (timeout).
- R5: A read request sends START, the device address with R/W=0 and both address bytes. It then sends a repeated START and the device address with R/W=1, reads N bytes and passes them out in order on the read stream.
- R6: During a read the host ACKs every byte except the last. It NACKs the last byte and then sends STOP.
- R7: If the device NACKs the device address or an address byte outside a polling phase, the block sends STOP and ends the request with error code 1. It moves no data after that.
- R8: Every request ends with exactly one done pulse lasting one cycle. Error code 0 means success. A request of length 0 completes at once with code 0 and sends no bus command.
- R9: Once asserted, cmd_valid and the command fields hold steady until cmd_ready. Once asserted, rd_valid and rd_data hold steady until rd_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | AW | Start byte address |
| req_len | input | LEN_W | Byte count |
| wr_valid | input | 1 | Write data byte offered |
| wr_ready | output | 1 | Write data byte taken |
| wr_data | input | 8 | Write data byte |
| rd_valid | output | 1 | Read data byte offered |
| rd_ready | input | 1 | Read data byte taken |
| rd_data | output | 8 | Read data byte |
| done | output | 1 | One-cycle completion pulse |
| done_err | output | 2 | 0 ok, 1 address NACK, 2 poll timeout |
| cmd_valid | output | 1 | Command offered to the engine |
| cmd_ready | input | 1 | Engine takes the command |
| cmd_op | output | 2 | 0 START, 1 WRITE, 2 READ, 3 STOP |
| cmd_wdata | output | 8 | Byte for WRITE |
| cmd_rd_ack | output | 1 | Host ACK (1) or NACK (0) for READ |
| rsp_valid | input | 1 | Engine response, at least one cycle after acceptance |
| rsp_nack | input | 1 | Device NACKed the written byte |
| rsp_rdata | input | 8 | Byte returned by READ |

## Verification
The bench builds the block with PAGE_BYTES=8, MAX_POLL=5 and LEN_W=8. It pairs the block with a behavioural engine and device that wrap inside an 8-byte page and stay busy for two polls after each segment. With these pages, a sweep over every start offset across a page and every length from 1 to 17 reaches segments that fill a page, stop short of one, or cross one or two boundaries. Each sweep point is read back, which checks the data, the segment count, the poll count and the read ACK pattern. The small poll limit makes the timeout path reachable. A wrong device address reaches the abort path.

// File: rtl/eeseq_pkg.sv
package eeseq_pkg;
  typedef enum logic [1:0] {OP_START = 2'd0, OP_WRITE = 2'd1, OP_READ = 2'd2, OP_STOP = 2'd3} op_t;

  localparam logic [1:0] ERR_OK      = 2'd0;
  localparam logic [1:0] ERR_NACK    = 2'd1;
  localparam logic [1:0] ERR_TIMEOUT = 2'd2;

  typedef enum logic [4:0] {
    S_IDLE, S_W_START, S_W_DEV, S_W_AH, S_W_AL, S_W_DATA, S_W_STOP,
    S_P_START, S_P_DEV, S_P_STOP,
    S_R_RSTART, S_R_DEV, S_R_BYTE, S_R_OUT, S_R_STOP,
    S_ERR_STOP, S_DONE
  } st_t;
endpackage

// File: rtl/eeseq_seg_calc.sv
// Length of the next write segment: the smaller of the bytes left and the room left in the page.
module eeseq_seg_calc #(
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 64,
  localparam int PW        = $clog2(PAGE_BYTES)
) (
  input  logic [PW-1:0]    offset,
  input  logic [LEN_W-1:0] remain,
  output logic [LEN_W-1:0] seg_len
);
  logic [LEN_W-1:0] room;
  always_comb begin
    room    = LEN_W'(PAGE_BYTES) - LEN_W'(offset);
    seg_len = (remain < room) ? remain : room;
  end
endmodule

// File: rtl/eeseq_poll_ctr.sv
// Counts refused polls in one polling phase.
module eeseq_poll_ctr #(
  parameter int MAX_POLL = 1000,
  localparam int CW      = $clog2(MAX_POLL + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic bump,
  output logic expired
);
  logic [CW-1:0] cnt;
  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (bump && !expired) cnt <= cnt + CW'(1);
  end
  assign expired = (cnt == CW'(MAX_POLL));

  // R4
  poll_bound_chk: assert property (@(posedge clk) disable iff (rst) cnt <= CW'(MAX_POLL));
endmodule

// File: rtl/eeprom_seq.sv
module eeprom_seq
  import eeseq_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h50,
  parameter int AW         = 15,
  parameter int LEN_W      = 16,
  parameter int PAGE_BYTES = 64,
  parameter int MAX_POLL   = 1000,
  localparam int PW        = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [7:0]       wr_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic [1:0]       done_err,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [1:0]       cmd_op,
  output logic [7:0]       cmd_wdata,
  output logic             cmd_rd_ack,
  input  logic             rsp_valid,
  input  logic             rsp_nack,
  input  logic [7:0]       rsp_rdata
);
  st_t              st;
  logic [1:0]       ph;        // 0 issue, 1 wait accept, 2 wait response
  logic             is_wr;
  logic [AW-1:0]    cur_addr;
  logic [LEN_W-1:0] remain;
  logic [LEN_W-1:0] seg_left;
  logic [AW-PW-1:0] seg_page;
  logic             poll_ok;
  logic [1:0]       err_r;
  logic [LEN_W-1:0] seg_len;
  logic             poll_expired;
  logic [15:0]      addr16;

  op_t              op_n;
  logic [7:0]       byte_n;
  logic             rack_n;
  logic             can_go;
  logic             got_rsp;

  eeseq_seg_calc #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_seg (
    .offset (cur_addr[PW-1:0]),
    .remain (remain),
    .seg_len(seg_len)
  );

  eeseq_poll_ctr #(.MAX_POLL(MAX_POLL)) u_poll (
    .clk    (clk),
    .rst    (rst),
    .clr    (st == S_W_STOP),
    .bump   (st == S_P_DEV && got_rsp && rsp_nack),
    .expired(poll_expired)
  );

  assign addr16    = 16'(cur_addr);
  assign got_rsp   = (ph == 2'd2) && rsp_valid;
  assign req_ready = (st == S_IDLE);
  assign wr_ready  = (st == S_W_DATA) && (ph == 2'd0);

  always_comb begin
    op_n   = OP_STOP;
    byte_n = 8'h00;
    rack_n = 1'b0;
    can_go = 1'b1;
    unique case (st)
      S_W_START, S_P_START, S_R_RSTART: op_n = OP_START;
      S_W_DEV, S_P_DEV: begin op_n = OP_WRITE; byte_n = {DEV_ADDR, 1'b0}; end
      S_R_DEV:          begin op_n = OP_WRITE; byte_n = {DEV_ADDR, 1'b1}; end
      S_W_AH:           begin op_n = OP_WRITE; byte_n = addr16[15:8]; end
      S_W_AL:           begin op_n = OP_WRITE; byte_n = addr16[7:0]; end
      S_W_DATA:         begin op_n = OP_WRITE; byte_n = wr_data; can_go = wr_valid; end
      S_R_BYTE:         begin op_n = OP_READ; rack_n = (remain != LEN_W'(1)); end
      default:          op_n = OP_STOP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      ph         <= 2'd0;
      is_wr      <= 1'b0;
      cur_addr   <= '0;
      remain     <= '0;
      seg_left   <= '0;
      seg_page   <= '0;
      poll_ok    <= 1'b0;
      err_r      <= ERR_OK;
      rd_valid   <= 1'b0;
      rd_data    <= 8'h00;
      done       <= 1'b0;
      done_err   <= ERR_OK;
      cmd_valid  <= 1'b0;
      cmd_op     <= OP_START;
      cmd_wdata  <= 8'h00;
      cmd_rd_ack <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        S_IDLE: if (req_valid) begin
          is_wr    <= req_write;
          cur_addr <= req_addr;
          remain   <= req_len;
          err_r    <= ERR_OK;
          ph       <= 2'd0;
          st       <= (req_len == '0) ? S_DONE : S_W_START;
        end
        S_R_OUT: if (rd_ready) begin
          rd_valid <= 1'b0;
          remain   <= remain - LEN_W'(1);
          st       <= (remain == LEN_W'(1)) ? S_R_STOP : S_R_BYTE;
        end
        S_DONE: begin
          done     <= 1'b1;
          done_err <= err_r;
          st       <= S_IDLE;
        end
        default: begin
          if (ph == 2'd0) begin
            if (can_go) begin
              cmd_valid  <= 1'b1;
              cmd_op     <= op_n;
              cmd_wdata  <= byte_n;
              cmd_rd_ack <= rack_n;
              ph         <= 2'd1;
            end
          end else if (ph == 2'd1) begin
            if (cmd_ready) begin
              cmd_valid <= 1'b0;
              ph        <= 2'd2;
            end
          end else if (rsp_valid) begin
            ph <= 2'd0;
            unique case (st)
              S_W_START: st <= S_W_DEV;
              S_W_DEV:   if (rsp_nack) begin err_r <= ERR_NACK; st <= S_ERR_STOP; end
                         else st <= S_W_AH;
              S_W_AH:    if (rsp_nack) begin err_r <= ERR_NACK; st <= S_ERR_STOP; end
                         else st <= S_W_AL;
              S_W_AL: begin
                if (rsp_nack) begin
                  err_r <= ERR_NACK;
                  st    <= S_ERR_STOP;
                end else if (is_wr) begin
                  seg_left <= seg_len;
                  seg_page <= cur_addr[AW-1:PW];
                  st       <= S_W_DATA;
                end else begin
                  st <= S_R_RSTART;
                end
              end
              S_W_DATA: begin
                cur_addr <= cur_addr + AW'(1);
                remain   <= remain - LEN_W'(1);
                seg_left <= seg_left - LEN_W'(1);
                if (seg_left == LEN_W'(1)) st <= S_W_STOP;
              end
              S_W_STOP:  st <= S_P_START;
              S_P_START: st <= S_P_DEV;
              S_P_DEV: begin
                poll_ok <= !rsp_nack;
                st      <= S_P_STOP;
              end
              S_P_STOP: begin
                if (poll_ok)           st <= (remain == '0) ? S_DONE : S_W_START;
                else if (poll_expired) begin err_r <= ERR_TIMEOUT; st <= S_DONE; end
                else                   st <= S_P_START;
              end
              S_R_RSTART: st <= S_R_DEV;
              S_R_DEV:    if (rsp_nack) begin err_r <= ERR_NACK; st <= S_ERR_STOP; end
                          else st <= S_R_BYTE;
              S_R_BYTE: begin
                rd_data  <= rsp_rdata;
                rd_valid <= 1'b1;
                st       <= S_R_OUT;
              end
              default: st <= S_DONE;
            endcase
          end
        end
      endcase
    end
  end

  // R2
  seg_in_page_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |-> (cur_addr[AW-1:PW] == seg_page));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R9
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_wdata) && $stable(cmd_rd_ack)));
  // R9
  rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!cmd_valid && !rd_valid));
endmodule

// File: tb/sim_eeprom_seq.sv
module sim_eeprom_seq;
  localparam int AW = 15, LW = 8, PG = 8, MAXP = 5, BUSY_N = 2;
  localparam logic [6:0] DEV = 7'h50;
  localparam logic [14:0] BASE = 15'h3A00;

  logic clk = 1'b0, rst = 1'b1;
  always #5 clk = ~clk;

  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic req_ready, wr_valid, wr_ready, rd_valid, done, cmd_valid, cmd_rd_ack;
  logic [7:0] wr_data, rd_data, cmd_wdata;
  logic [1:0] done_err, cmd_op;
  logic cmd_ready, rsp_valid = 1'b0, rsp_nack = 1'b0, rd_ready;
  logic [7:0] rsp_rdata = 8'h00;

  eeprom_seq #(.DEV_ADDR(DEV), .AW(AW), .LEN_W(LW), .PAGE_BYTES(PG), .MAX_POLL(MAXP)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .done(done), .done_err(done_err), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_rd_ack(cmd_rd_ack), .rsp_valid(rsp_valid),
    .rsp_nack(rsp_nack), .rsp_rdata(rsp_rdata));

  int total = 0, bad = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // streams
  logic [7:0] wbuf [256];
  logic [7:0] rbuf [256];
  int wptr = 0, wstart = 0, wlen = 0, rcnt = 0;
  assign wr_valid = (wptr - wstart) < wlen;
  assign wr_data  = wbuf[(wptr - wstart) & 255];
  assign rd_ready = (cyc % 3) != 0;
  always @(posedge clk) begin
    if (wr_valid && wr_ready) wptr <= wptr + 1;
    if (rd_valid && rd_ready) begin rbuf[rcnt & 255] <= rd_data; rcnt <= rcnt + 1; end
  end

  // behavioural engine + device
  logic [7:0] mem [256];
  logic pend = 1'b0, wrote = 1'b0, stuck = 1'b0;
  logic [2:0] mph = 3'd0;
  logic [14:0] ptr = '0;
  logic [6:0] model_dev = DEV;
  int busy_cnt = 0, n_dev_w = 0, n_stop = 0, n_rack = 0, n_rnack = 0, n_seg = 0, n_badhi = 0, n_cmd = 0;
  assign cmd_ready = !pend && !rsp_valid && ((cyc % 4) != 1);

  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (pend) begin rsp_valid <= 1'b1; pend <= 1'b0; end
    if (cmd_valid && cmd_ready) begin
      pend <= 1'b1; rsp_nack <= 1'b0; n_cmd <= n_cmd + 1;
      case (cmd_op)
        2'd0: mph <= 3'd0;
        2'd1: case (mph)
          3'd0: begin
            if (!cmd_wdata[0]) n_dev_w <= n_dev_w + 1;
            if (cmd_wdata[7:1] != model_dev || busy_cnt > 0) begin
              rsp_nack <= 1'b1; mph <= 3'd5;
              if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
            end else mph <= cmd_wdata[0] ? 3'd4 : 3'd1;
          end
          3'd1: begin ptr[14:8] <= cmd_wdata[6:0]; if (cmd_wdata != 8'h3A) n_badhi <= n_badhi + 1; mph <= 3'd2; end
          3'd2: begin ptr[7:0] <= cmd_wdata; mph <= 3'd3; end
          3'd3: begin
            mem[ptr[7:0]] <= cmd_wdata; wrote <= 1'b1;
            ptr <= (ptr & ~15'(PG - 1)) | ((ptr + 15'd1) & 15'(PG - 1));
          end
          default: rsp_nack <= 1'b1;
        endcase
        2'd2: begin
          rsp_rdata <= mem[ptr[7:0]]; ptr <= ptr + 15'd1;
          if (cmd_rd_ack) n_rack <= n_rack + 1; else n_rnack <= n_rnack + 1;
        end
        default: begin
          n_stop <= n_stop + 1;
          if (wrote) begin busy_cnt <= stuck ? MAXP + 1 : BUSY_N; wrote <= 1'b0; n_seg <= n_seg + 1; end
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin bad++; $display("FAIL %s: actual=%0d expected=%0d", what, act, exp); end
  endtask

  task automatic run_req(input bit w, input logic [14:0] a, input int n, output logic [1:0] e);
    @(negedge clk);
    req_write = w; req_addr = a; req_len = LW'(n); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    e = done_err;
  endtask

  function automatic int exp_segs(input int a, input int n);
    int s = 0;
    while (n > 0) begin
      int room = PG - (a % PG);
      int t = (n < room) ? n : room;
      a += t; n -= t; s++;
    end
    return s;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0] e;
    int s0, d0, ra0, rn0, r0, c0, w0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(req_ready && !done && !cmd_valid && !rd_valid, "R8 reset idle", int'(req_ready), 1);

    // R8 zero length
    c0 = n_cmd;
    run_req(1'b1, BASE, 0, e);
    chk(e == 2'd0, "R8 len0 err", int'(e), 0);
    chk(n_cmd == c0, "R8 len0 no bus cmd", n_cmd - c0, 0);

    // R1 R2 R3 R5 R6 sweep over offsets and lengths
    for (int off = 0; off < 9; off++) begin
      for (int n = 1; n <= 17; n++) begin
        logic [14:0] a = BASE + 15'(8 + off);
        for (int i = 0; i < n; i++) wbuf[i] = 8'(off * 31 + n * 7 + i * 13 + 5);
        wstart = wptr; wlen = n;
        s0 = n_seg; d0 = n_dev_w;
        run_req(1'b1, a, n, e);
        chk(e == 2'd0, "R8 write err", int'(e), 0);
        chk(n_seg - s0 == exp_segs(int'(a), n), "R2 segment count", n_seg - s0, exp_segs(int'(a), n));
        chk(n_dev_w - d0 == exp_segs(int'(a), n) * (2 + BUSY_N), "R3 poll addr count",
            n_dev_w - d0, exp_segs(int'(a), n) * (2 + BUSY_N));
        wlen = 0;
        r0 = rcnt; ra0 = n_rack; rn0 = n_rnack;
        run_req(1'b0, a, n, e);
        chk(e == 2'd0, "R5 read err", int'(e), 0);
        chk(rcnt - r0 == n, "R5 read count", rcnt - r0, n);
        for (int i = 0; i < n; i++)
          chk(rbuf[(r0 + i) & 255] == wbuf[i], "R1 R5 data", int'(rbuf[(r0 + i) & 255]), int'(wbuf[i]));
        chk(n_rnack - rn0 == 1 && n_rack - ra0 == n - 1, "R6 ack pattern", n_rack - ra0, n - 1);
      end
    end
    chk(n_badhi == 0, "R1 high address byte", n_badhi, 0);

    // R4 poll timeout
    stuck = 1'b1;
    for (int i = 0; i < 1; i++) wbuf[i] = 8'hA5;
    wstart = wptr; wlen = 1; d0 = n_dev_w;
    run_req(1'b1, BASE + 15'd3, 1, e);
    stuck = 1'b0;
    chk(e == 2'd2, "R4 timeout code", int'(e), 2);
    chk(n_dev_w - d0 == 1 + MAXP, "R4 poll attempts", n_dev_w - d0, 1 + MAXP);

    // R7 address NACK (device still busy) on write: stop sent, no data taken
    wstart = wptr; wlen = 1; w0 = wptr; s0 = n_stop;
    run_req(1'b1, BASE + 15'd4, 1, e);
    chk(e == 2'd1, "R7 write nack code", int'(e), 1);
    chk(n_stop - s0 == 1, "R7 write stop", n_stop - s0, 1);
    chk(wptr == w0, "R7 no data consumed", wptr - w0, 0);
    wlen = 0;

    // R7 wrong device on read: stop, no read bytes
    model_dev = 7'h51;
    r0 = rcnt; s0 = n_stop; c0 = n_rack + n_rnack;
    run_req(1'b0, BASE, 4, e);
    chk(e == 2'd1, "R7 read nack code", int'(e), 1);
    chk(n_stop - s0 == 1, "R7 read stop", n_stop - s0, 1);
    chk(rcnt == r0 && n_rack + n_rnack == c0, "R7 no read data", rcnt - r0, 0);
    model_dev = DEV;

    // R8 recovery after errors
    r0 = rcnt;
    run_req(1'b0, BASE + 15'd8, 3, e);
    chk(e == 2'd0 && rcnt - r0 == 3, "R8 recover", rcnt - r0, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule